// File: doc/BRIEF.md
# Interrupt Flag and Watchdog Service Register

This block is a single byte-wide special-function register that serves two purposes. Its low bits are sticky interrupt flags: one is set by a pulse from the data-transfer-busy source, and one by the one-second tick from the real-time clock. The interrupt controller sees each flag as a level until software clears it. Its top bit is a write-only strobe that tells an external watchdog counter to start counting again from the beginning.

Software reaches the register over a simple byte bus: an address, a write enable, write data and combinational read data. Writes always cover the whole byte. A flag is cleared by writing 0 in its position. Every other position is written as 1, and a 1 leaves that flag as it is. Software can never set a flag. If a hardware event and a software clear reach the same flag in the same cycle, the event wins, so no event is lost.

Top module: `irq_wdi_reg`

## Requirements
- R1: After reset both flags are 0 and the watchdog restart output is 0.
- R2: A transfer-busy event pulse sets flag bit 0 (irq_flags[0]) at the next clock edge. The flag then stays 1 until software clears it.
- R3: A one-second RTC event pulse sets flag bit 1 (irq_flags[1]) at the next clock edge. The flag then stays 1 until software clears it.
- R4: A write to the register address (0xE8) with a 0 in bit 0 or bit 1 clears that flag at the next edge. A flag whose bit is written as 1 keeps its value.
- R5: When a hardware event and a software clear hit the same flag in the same cycle, the flag is 1 after the edge.
- R6: A write to 0xE8 with bit 7 set drives wdt_restart high for exactly the one cycle after the write edge. Back-to-back writes give back-to-back pulses. A write with bit 7 clear gives no pulse.
- R7: When bus_addr is 0xE8, bus_rdata carries the flags in bits 1:0 and reads 0 in bits 7:2, which includes the restart bit. At any other address, bus_rdata is 0.
- R8: A write to any address other than 0xE8 changes no flag and gives no restart pulse.
- R9: A write of 1 to a flag bit never sets a flag that is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Byte write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| xfer_evt | input | 1 | Transfer-busy event pulse |
| rtc_evt | input | 1 | One-second RTC event pulse |
| irq_flags | output | 2 | Flag levels to the interrupt controller |
| wdt_restart | output | 1 | One-cycle watchdog restart pulse |

## Verification
The assertions check a set of relations on every cycle:
- an event always leaves its flag set on the next cycle;
- a flag that is 0, with no event, stays 0 whatever software writes;
- the restart output follows exactly the qualifying writes of the cycle before;
- the upper read bits are always zero;
- writes to other addresses leave the flags alone.

Only the bench scenarios show certain cases:
- that a clear removes exactly the chosen flag while its neighbour holds;
- the ordering of set against clear with real data patterns;
- the readback values;
- that a reset in mid-run clears flags that were set.

// File: rtl/irq_wdi_pkg.sv
package irq_wdi_pkg;
    localparam int NUM_FLAGS = 2;
    localparam int XFER_BIT  = 0;
    localparam int RTC_BIT   = 1;

    typedef struct packed {
        logic flag;
    } flag_st_t;

    typedef struct packed {
        logic pulse;
    } strobe_st_t;
endpackage

// File: rtl/irq_wdi_flag.sv
module irq_wdi_flag
    import irq_wdi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic flag
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit && !wr_bit)
            st_d.flag = 1'b0;
        if (set_evt)
            st_d.flag = 1'b1;   // set has priority over clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R2 / R3 / R5: an event always leaves the flag set
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    // R9: software alone can never raise a flag
    p_no_sw_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !set_evt) |=> !flag);

    // R2: without a clear the flag is sticky
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_hit && !wr_bit)) |=> flag);
endmodule

// File: rtl/irq_wdi_strobe.sv
module irq_wdi_strobe
    import irq_wdi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    strobe_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    // R6: pulse follows a qualifying write by one cycle
    p_pulse_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pulse);

    // R6 / R8: no qualifying write, no pulse
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !pulse);
endmodule

// File: rtl/irq_wdi_reg.sv
module irq_wdi_reg
    import irq_wdi_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hE8,
    parameter int                WDT_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              xfer_evt,
    input  logic              rtc_evt,
    output logic [NUM_FLAGS-1:0] irq_flags,
    output logic              wdt_restart
);
    logic                 sel;
    logic                 wr_hit;
    logic [NUM_FLAGS-1:0] evt;
    logic                 wdata_unused;

    assign sel    = (bus_addr == REG_ADDR);
    assign wr_hit = bus_wr && sel;

    always_comb begin
        evt           = '0;
        evt[XFER_BIT] = xfer_evt;
        evt[RTC_BIT]  = rtc_evt;
    end

    assign wdata_unused = ^bus_wdata;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        irq_wdi_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (evt[i]),
            .wr_hit  (wr_hit),
            .wr_bit  (bus_wdata[i]),
            .flag    (irq_flags[i])
        );
    end

    irq_wdi_strobe u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (wr_hit && bus_wdata[WDT_BIT]),
        .pulse (wdt_restart)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel)
            bus_rdata[NUM_FLAGS-1:0] = irq_flags;
    end

    // R7: bits above the flags always read zero
    p_rdata_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_FLAGS] == '0);

    // R8: a write elsewhere, with no event, leaves the flags alone
    p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !sel && !xfer_evt && !rtc_evt) |=> $stable(irq_flags));
endmodule

// File: tb/irq_wdi_reg_test.sv
`timescale 1ns/1ps
module irq_wdi_reg_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       xfer_evt;
    logic       rtc_evt;
    logic [1:0] irq_flags;
    logic       wdt_restart;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_wdi_reg uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_evt(xfer_evt),
        .rtc_evt(rtc_evt), .irq_flags(irq_flags), .wdt_restart(wdt_restart)
    );

    // {xfer, rtc, wr, addr[7:0], wdata[7:0], exp_flags[1:0], exp_restart}
    localparam int NV = 14;
    localparam logic [21:0] VECS [0:NV-1] = '{
        {1'b1,1'b0,1'b0,8'h00,8'h00,2'b01,1'b0}, // R2 set bit0
        {1'b0,1'b0,1'b0,8'h00,8'h00,2'b01,1'b0}, // R2 sticky
        {1'b0,1'b1,1'b0,8'h00,8'h00,2'b11,1'b0}, // R3 set bit1
        {1'b0,1'b0,1'b1,8'hE8,8'hFE,2'b10,1'b1}, // R4 clear bit0, R6 bit7
        {1'b0,1'b0,1'b1,8'hE8,8'h7F,2'b10,1'b0}, // R4 keep, R6 no pulse
        {1'b0,1'b0,1'b0,8'h00,8'h00,2'b10,1'b0}, // idle
        {1'b0,1'b0,1'b1,8'hE8,8'hFD,2'b00,1'b1}, // R4 clear bit1
        {1'b1,1'b0,1'b1,8'hE8,8'h7F,2'b01,1'b0}, // R2 set during write
        {1'b1,1'b0,1'b1,8'hE8,8'h7C,2'b01,1'b0}, // R5 set beats clear
        {1'b0,1'b0,1'b1,8'hE9,8'h00,2'b01,1'b0}, // R8 other address
        {1'b0,1'b0,1'b1,8'hE8,8'h7F,2'b01,1'b0}, // R9 write 1 no set
        {1'b0,1'b1,1'b1,8'hE8,8'h00,2'b10,1'b0}, // R5 bit1 set, bit0 clr
        {1'b0,1'b0,1'b1,8'hE7,8'h80,2'b10,1'b0}, // R8 no restart
        {1'b0,1'b0,1'b1,8'hE8,8'h00,2'b00,1'b0}  // R4 clear all
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic x, input logic r, input logic w,
                         input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        xfer_evt = x; rtc_evt = r; bus_wr = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        xfer_evt = 0; rtc_evt = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 flags", {6'd0, irq_flags}, 8'h00);
        chk("R1 restart", {7'd0, wdt_restart}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i][21], VECS[i][20], VECS[i][19], VECS[i][18:11], VECS[i][10:3]);
            step();
            chk($sformatf("R2-R9 vec%0d flags", i), {6'd0, irq_flags}, {6'd0, VECS[i][2:1]});
            chk($sformatf("R6 vec%0d restart", i), {7'd0, wdt_restart}, {7'd0, VECS[i][0]});
        end

        // R7 readback
        drive(1, 0, 0, 8'hE8, 8'h00); step();
        drive(0, 0, 0, 8'hE8, 8'h00); #1;
        chk("R7 read 01", bus_rdata, 8'h01);
        drive(0, 1, 0, 8'hE8, 8'h00); step();
        drive(0, 0, 0, 8'hE8, 8'h00); #1;
        chk("R7 read 03", bus_rdata, 8'h03);
        drive(0, 0, 0, 8'h12, 8'h00); #1;
        chk("R7 other addr reads 0", bus_rdata, 8'h00);

        // R6 back-to-back pulses, then single drop
        drive(0, 0, 1, 8'hE8, 8'hFF); step();
        chk("R6 pulse 1", {7'd0, wdt_restart}, 8'h01);
        drive(0, 0, 1, 8'hE8, 8'h80); step();
        chk("R6 pulse 2", {7'd0, wdt_restart}, 8'h01);
        chk("R4 flags after 0x80 cleared", {6'd0, irq_flags}, 8'h00);
        drive(0, 0, 0, 8'hE8, 8'h00); step();
        chk("R6 pulse ends", {7'd0, wdt_restart}, 8'h00);
        #1; chk("R7 restart bit reads 0", bus_rdata, 8'h00);

        // R1 mid-run reset clears set flags
        drive(1, 1, 0, 8'h00, 8'h00); step();
        chk("R2 R3 both set", {6'd0, irq_flags}, 8'h03);
        drive(0, 0, 0, 8'h00, 8'h00); rst_n = 1'b0; step();
        chk("R1 mid reset flags", {6'd0, irq_flags}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule